// File: doc/BRIEF.md
# Banked Processor Register File

This block holds the architectural registers of a small soft processor in a single synchronous RAM. Each instruction names a register with a 6-bit specifier. A specifier whose top bit is 0 reaches one of 32 shared registers, and these are visible at all times. A specifier whose top bit is 1 reaches one of 32 registers in a window, and that window can be switched. A 4-bit active-bank register picks which of 15 windows is in use. Software switches it to give each thread or subroutine its own set of registers, and the shared registers stay in place across the switch.

The block has two read ports and one write port. Reads are synchronous and return data one cycle after the address is presented. The RAM address is formed as {bank, index}, with the bank field forced to 0 for shared registers. Bank value 0 is therefore reserved, and a request to select it is dropped. The pipeline drives addresses every cycle and takes the read data one cycle later, with no handshake.

Top module: `bank_regfile`

## Requirements
- R1: A specifier with bit 5 = 0 selects shared register idx = spec[4:0] at RAM address {4'b0000, idx}, and reaches the same storage whatever the active bank.
- R2: A specifier with bit 5 = 1 selects RAM address {activeBank, spec[4:0]}, so the same window register in two different banks holds independent values.
- R3: Read data on each read port appears one clock after the read address is sampled, and holds the stored value at that address.
- R4: When a read port addresses the same RAM location that the write port writes in the same cycle (wrEn = 1), that port returns the new write data one cycle later.
- R5: A bank-select write (bankWrEn = 1, bankWrData non-zero) changes activeBank at the next clock edge. Reads and writes issued in the same cycle as the bank-select write still use the old bank.
- R6: A bank-select write with bankWrData = 0 is ignored, and activeBank and the window mapping remain unchanged.
- R7: After reset, activeBank is 1. Register contents are undefined until written.
- R8: The two read ports are independent and may address any two registers in the same cycle.
- R9: With wrEn = 0, no register changes, whatever wrAddr and wrData carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 6 | Read port A register specifier |
| rdAddrB | input | 6 | Read port B register specifier |
| rdDataA | output | 32 | Read port A data, one cycle after the address |
| rdDataB | output | 32 | Read port B data, one cycle after the address |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 6 | Write register specifier |
| wrData | input | 32 | Write data |
| bankWrEn | input | 1 | Bank-select write strobe |
| bankWrData | input | 4 | New active bank (0 is ignored) |
| activeBank | output | 4 | Currently active bank |

## Verification
The hardest situation to create from the ports is a single cycle that combines a bank switch with a write and a read to a window register. The expected result in that cycle depends on the old bank, while everything after it depends on the new one. The stimulus sets this up deliberately. It fills the same window index in two banks with different values, then switches bank in the same cycle as a write and a same-address read. It then reads the index back from both banks to show where the write landed. A long pseudo-random run adds chance collisions between reads, writes and bank switches, including zero selects. The bench checks every read of a location it has already written against its own model of the address split.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic wrFire;   // commit write this cycle
    logic bypassA;  // port A reads the location being written
    logic bypassB;  // port B reads the location being written
  } ctlStrobes_t;
endpackage

// File: rtl/bank_regfile_ctrl.sv
module bank_regfile_ctrl
  import bank_regfile_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int BANK_W = 4,
  parameter int RESET_BANK = 1,
  localparam int SPEC_W = IDX_W + 1,
  localparam int PHYS_W = BANK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPEC_W-1:0] rdAddrA,
  input  logic [SPEC_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrAddr,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrData,
  output logic [BANK_W-1:0] activeBank,
  output logic [PHYS_W-1:0] physRdA,
  output logic [PHYS_W-1:0] physRdB,
  output logic [PHYS_W-1:0] physWr,
  output ctlStrobes_t       strobes
);
  localparam int N_PORTS = 3;

  logic [BANK_W-1:0] bankQ;
  logic [N_PORTS-1:0][SPEC_W-1:0] specs;
  logic [N_PORTS-1:0][PHYS_W-1:0] phys;

  // Bank-select register: zero is reserved for the shared half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankQ <= BANK_W'(RESET_BANK);
    else if (bankWrEn && (bankWrData != '0))
      bankQ <= bankWrData;
  end

  assign activeBank = bankQ;
  assign specs = {wrAddr, rdAddrB, rdAddrA};

  // One address former per access port.
  for (genvar p = 0; p < N_PORTS; p++) begin : gAddr
    logic windowSel;
    assign windowSel = specs[p][SPEC_W-1];
    assign phys[p] = windowSel ? {bankQ, specs[p][IDX_W-1:0]}
                               : {{BANK_W{1'b0}}, specs[p][IDX_W-1:0]};
  end

  assign physRdA = phys[0];
  assign physRdB = phys[1];
  assign physWr  = phys[2];

  always_comb begin
    strobes.wrFire  = wrEn;
    strobes.bypassA = wrEn && (phys[2] == phys[0]);
    strobes.bypassB = wrEn && (phys[2] == phys[1]);
  end
endmodule

// File: rtl/bank_regfile_datapath.sv
module bank_regfile_datapath
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PHYS_W = 9,
  localparam int DEPTH = 1 << PHYS_W
) (
  input  logic              clk,
  input  ctlStrobes_t       strobes,
  input  logic [PHYS_W-1:0] physRdA,
  input  logic [PHYS_W-1:0] physRdB,
  input  logic [PHYS_W-1:0] physWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int N_RD = 2;

  logic [DATA_W-1:0] regMem [DEPTH];
  logic [N_RD-1:0][PHYS_W-1:0] rdPhys;
  logic [N_RD-1:0] rdBypass;
  logic [N_RD-1:0][DATA_W-1:0] rdQ;

  assign rdPhys   = {physRdB, physRdA};
  assign rdBypass = {strobes.bypassB, strobes.bypassA};

  always_ff @(posedge clk) begin
    if (strobes.wrFire)
      regMem[physWr] <= wrData;
  end

  // Synchronous read ports with write-first forwarding.
  for (genvar r = 0; r < N_RD; r++) begin : gRead
    always_ff @(posedge clk) begin
      if (rdBypass[r])
        rdQ[r] <= wrData;
      else
        rdQ[r] <= regMem[rdPhys[r]];
    end
  end

  assign rdDataA = rdQ[0];
  assign rdDataB = rdQ[1];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int BANK_W = 4,
  localparam int SPEC_W = IDX_W + 1,
  localparam int PHYS_W = BANK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPEC_W-1:0] rdAddrA,
  input  logic [SPEC_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrData,
  output logic [BANK_W-1:0] activeBank
);
  ctlStrobes_t       strobes;
  logic [PHYS_W-1:0] physRdA;
  logic [PHYS_W-1:0] physRdB;
  logic [PHYS_W-1:0] physWr;

  bank_regfile_ctrl #(
    .IDX_W(IDX_W), .BANK_W(BANK_W), .RESET_BANK(1)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .activeBank(activeBank),
    .physRdA(physRdA), .physRdB(physRdB), .physWr(physWr),
    .strobes(strobes)
  );

  bank_regfile_datapath #(
    .DATA_W(DATA_W), .PHYS_W(PHYS_W)
  ) uData (
    .clk(clk), .strobes(strobes),
    .physRdA(physRdA), .physRdB(physRdB), .physWr(physWr),
    .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int SPEC_W = 6,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [SPEC_W-1:0] rdAddrA,
  input logic [SPEC_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [SPEC_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              bankWrEn,
  input logic [BANK_W-1:0] bankWrData,
  input logic [BANK_W-1:0] activeBank
);
  // R7: reset places the bank at 1
  a_r7_reset_bank: assert property (@(posedge clk)
    !rstN |=> activeBank == BANK_W'(1));

  // R5: non-zero select lands on the next edge
  a_r5_bank_update: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn && (bankWrData != '0) |=> activeBank == $past(bankWrData));

  // R5: without a select the bank holds
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bankWrEn |=> $stable(activeBank));

  // R6: zero select is ignored
  a_r6_zero_ignored: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn && (bankWrData == '0) |=> $stable(activeBank));

  // R2: the reserved bank is never active
  a_r2_bank_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    activeBank != '0);

  // R4: same-cycle read of the written register on port A
  a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (rdAddrA == wrAddr) |=> rdDataA == $past(wrData));

  // R4: same-cycle read of the written register on port B
  a_r4_bypass_b: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (rdAddrB == wrAddr) |=> rdDataB == $past(wrData));
endmodule

bind bank_regfile bank_regfile_chk #(
  .DATA_W(DATA_W), .SPEC_W(SPEC_W), .BANK_W(BANK_W)
) uChk (
  .clk(clk), .rstN(rstN),
  .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
  .rdDataA(rdDataA), .rdDataB(rdDataB),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .bankWrEn(bankWrEn), .bankWrData(bankWrData),
  .activeBank(activeBank)
);

// File: tb/bank_regfile_test.sv
module bank_regfile_test;
  localparam int DW = 32;
  localparam int NLOC = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic wrEn = 1'b0, bankWrEn = 1'b0;
  logic [3:0] bankWrData = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic [3:0] activeBank;

  always #2.5 clk = ~clk;  // 200 MHz

  bank_regfile uut (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .activeBank(activeBank)
  );

  typedef struct {
    bit chkA;
    bit chkB;
    logic [DW-1:0] expA;
    logic [DW-1:0] expB;
    logic [3:0] expBank;
    string tag;
  } item_t;

  item_t sbQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit started = 0;

  // Independent model.
  logic [DW-1:0] model [NLOC];
  bit written [NLOC];
  logic [3:0] mBank = 4'd1;
  logic [31:0] rng = 32'h1234_5678;

  function automatic int physOf(logic [5:0] spec, logic [3:0] bank);
    if (spec[5]) return {bank, spec[4:0]};
    return {4'b0000, spec[4:0]};
  endfunction

  function automatic logic [31:0] nextRand(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic issue(logic [5:0] ra, logic [5:0] rb, bit we, logic [5:0] wa,
                       logic [DW-1:0] wd, bit bwe, logic [3:0] bd, string tag);
    item_t it;
    int pa, pb, pw;
    @(negedge clk);
    rdAddrA = ra; rdAddrB = rb; wrEn = we; wrAddr = wa; wrData = wd;
    bankWrEn = bwe; bankWrData = bd;
    pa = physOf(ra, mBank);
    pb = physOf(rb, mBank);
    pw = physOf(wa, mBank);
    it.tag  = tag;
    it.chkA = (we && pw == pa) || written[pa];
    it.chkB = (we && pw == pb) || written[pb];
    it.expA = (we && pw == pa) ? wd : model[pa];
    it.expB = (we && pw == pb) ? wd : model[pb];
    if (we) begin
      model[pw] = wd;
      written[pw] = 1;
    end
    if (bwe && bd != 0) mBank = bd;
    it.expBank = mBank;
    sbQ.push_back(it);
    started = 1;
  endtask

  task automatic idle();
    issue(6'd0, 6'd0, 0, 6'd0, '0, 0, 4'd0, "R3 idle");
  endtask

  // Monitor: compares one scoreboard item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (started && sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        if (it.chkA) check(rdDataA === it.expA, {it.tag, " portA"}, rdDataA, it.expA);
        if (it.chkB) check(rdDataB === it.expB, {it.tag, " portB"}, rdDataB, it.expB);
        check(activeBank === it.expBank, {it.tag, " bank"},
              DW'(activeBank), DW'(it.expBank));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NLOC; i++) written[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset bank
    check(activeBank === 4'd1, "R7 reset bank", DW'(activeBank), 32'd1);

    // R1 / R3: shared registers, including index boundaries
    issue(6'd0, 6'd0, 1, 6'd0,  32'hA000_0000, 0, 4'd0, "R1 wr g0");
    issue(6'd0, 6'd0, 1, 6'd31, 32'hA000_001F, 0, 4'd0, "R1 wr g31");
    issue(6'd0, 6'd0, 1, 6'd3,  32'hA000_0003, 0, 4'd0, "R1 wr g3");
    issue(6'd3, 6'd31, 0, 6'd0, '0, 0, 4'd0, "R3 rd g3 g31");
    // R8: both ports read different registers
    issue(6'd31, 6'd0, 0, 6'd0, '0, 0, 4'd0, "R8 rd g31 g0");

    // R2: window register 5 in bank 1
    issue(6'd0, 6'd0, 1, 6'd37, 32'hB100_0005, 0, 4'd0, "R2 wr b1w5");
    issue(6'd37, 6'd3, 0, 6'd0, '0, 0, 4'd0, "R2 rd b1w5");
    // R5: switch to bank 2 while writing w5 and reading it: old bank used
    issue(6'd37, 6'd5, 1, 6'd37, 32'hB1FF_0005, 1, 4'd2, "R5 same-cycle old bank");
    issue(6'd0, 6'd0, 1, 6'd37, 32'hB200_0005, 0, 4'd0, "R5 wr b2w5");
    issue(6'd37, 6'd3, 0, 6'd0, '0, 0, 4'd0, "R2 rd b2w5 and R1 g3 in bank2");
    // R6: zero select ignored, still bank 2
    issue(6'd37, 6'd0, 0, 6'd0, '0, 1, 4'd0, "R6 zero select");
    issue(6'd37, 6'd0, 0, 6'd0, '0, 0, 4'd0, "R6 after zero select");
    // back to bank 1: sees the same-cycle write
    issue(6'd0, 6'd0, 0, 6'd0, '0, 1, 4'd1, "R5 sel b1");
    issue(6'd37, 6'd37, 0, 6'd0, '0, 0, 4'd0, "R5 rd b1w5");

    // R4: write-first on both ports
    issue(6'd40, 6'd40, 1, 6'd40, 32'hC0DE_0008, 0, 4'd0, "R4 bypass both");
    issue(6'd3, 6'd40, 1, 6'd3, 32'hC0DE_0003, 0, 4'd0, "R4 bypass shared");
    issue(6'd3, 6'd40, 0, 6'd0, '0, 0, 4'd0, "R4 readback");

    // R9: write strobe low changes nothing
    issue(6'd0, 6'd0, 0, 6'd3, 32'hDEAD_BEEF, 0, 4'd0, "R9 no strobe");
    issue(6'd3, 6'd0, 0, 6'd0, '0, 0, 4'd0, "R9 readback");

    // Top bank, top index (address 511), and shared reg from bank 15
    issue(6'd0, 6'd0, 0, 6'd0, '0, 1, 4'd15, "R5 sel b15");
    issue(6'd0, 6'd0, 1, 6'd63, 32'hF00F_001F, 0, 4'd0, "R2 wr b15w31");
    issue(6'd63, 6'd31, 0, 6'd0, '0, 0, 4'd0, "R2 rd b15w31 R1 g31");

    // Pseudo-random mix of all of the above
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ra, rb, wa;
      bit we, bwe;
      logic [3:0] bd;
      logic [DW-1:0] wd;
      rng = nextRand(rng); ra = rng[5:0]; rb = rng[11:6]; wa = rng[17:12];
      we = rng[18] | rng[19]; bwe = (rng[22:20] == 3'd0); bd = rng[26:23];
      rng = nextRand(rng); wd = rng;
      if (rng[0]) wa = ra;
      issue(ra, rb, we, wa, wd, bwe, bd, "R2 R4 R5 R6 mix");
    end

    idle();
    idle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule